// File: doc/BRIEF.md
# Sizable Base Address Register Bank

This block holds the base address registers of an endpoint's configuration header. Each slot defines one address window, and parameters fix the window's size, which is always a power of two. The header logic around the block sends dword accesses to it. Each access carries a slot index, four byte enables, a write strobe and write data, and the block answers with the read data of the indexed slot in the same cycle. Address decoding logic reads the programmed 64-bit base of every window from a flat output bus.

The block forces the address bits below the window size to zero, so a base can only land on a boundary aligned to the window size. Software finds a window's size by writing all ones to the slot and reading the value back. The low four bits of a normal slot are constant attribute bits, set from parameters: bit 0 is 1 for I/O and 0 for memory, bits 2:1 are 10 for a 64-bit window and 00 otherwise, and bit 3 marks prefetchable memory. A window flagged as 64-bit takes two slots. The slot after it is fully writable and holds bits 63:32 of the base. A slot with size zero is not implemented.

Top module: `bar_bank`

## Requirements
- R1: In a slot of window size 2^k, the address bits below bit k always read as zero, whatever was written. Example: a 4 KiB slot written with 0x00001080 reads 0x00001000.
- R2: In a normal slot, bits 3:0 always read as the parameter attributes: bit 0 is I/O, bits 2:1 are 10 for 64-bit and 00 for 32-bit, and bit 3 is prefetchable. Writes never change these bits.
- R3: After all ones are written, a normal slot reads the size mask with the attribute bits merged in. With the default parameters: slot 0 (4 KiB) reads 0xFFFFF000, slot 1 (64 KiB, 64-bit, prefetchable) reads 0xFFFF000C, slot 3 (256 B I/O) reads 0xFFFFFF01, and slot 5 (1 MiB) reads 0xFFF00000.
- R4: The slot after a 64-bit window holds bits 63:32 of its base. When the window is no larger than 4 GiB, all 32 bits of that slot are writable and read back as written.
- R5: A slot with size parameter zero reads as zero after any write. An index at or above the slot count reads as zero, and a write to it changes no slot.
- R6: Byte enable n gates write-data bits 8n+7:8n. A disabled byte keeps its stored value.
- R7: After reset, every writable address bit is zero, so each slot reads only its attribute bits.
- R8: The base output for slot j is bits 64j+63:64j of `base_addr_o`. For a 32-bit window it is the aligned base zero-extended to 64 bits. For a 64-bit window it is {upper slot, aligned lower slot}, with the attribute bits cleared. For an upper slot or an unimplemented slot it is zero.
- R9: Without the write strobe no slot changes. Read data is combinational from the index, and a write shows in the read data from the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idx | input | IDX_W (3) | Slot index of the access |
| cfg_we | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the indexed slot |
| base_addr_o | output | NUM_SLOTS*64 (384) | Aligned 64-bit base of each slot |

## Verification
The assertions assume that the parameters have already passed the elaboration checks: no 64-bit window in the last slot, no size parameter on an upper slot, and no size below 16 bytes. They also assume that the index, byte enables and strobe are stable around the clock edge. The bench changes every input on the falling edge and samples the read data one time unit after it drives the index. It also drives out-of-range indices on purpose, so that the decoder's one-hot check and its empty-select check both see real traffic.

// File: rtl/bar_bank_pkg.sv
package bar_bank_pkg;

   typedef enum logic [1:0] {
      SLOT_OFF  = 2'd0,
      SLOT_LO32 = 2'd1,
      SLOT_LO64 = 2'd2,
      SLOT_HI64 = 2'd3
   } slot_role_e;

   // writable bits of a lower slot for a window of 2**lg bytes
   function automatic logic [31:0] lo_wmask(input int unsigned lg);
      if (lg == 0 || lg >= 32) return 32'h0;
      return ~((32'd1 << lg) - 32'd1);
   endfunction

   // writable bits of an upper slot for a window of 2**lg bytes
   function automatic logic [31:0] hi_wmask(input int unsigned lg);
      if (lg <= 32) return 32'hFFFF_FFFF;
      return ~((32'd1 << (lg - 32)) - 32'd1);
   endfunction

   function automatic logic [3:0] attr_bits(input logic io, input logic is64,
                                            input logic pref);
      return {pref, is64, 1'b0, io};
   endfunction

   function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                            input logic [31:0] new_v,
                                            input logic [3:0]  be);
      logic [31:0] r;
      for (int b = 0; b < 4; b++)
         r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
      return r;
   endfunction

endpackage

// File: rtl/bar_wr_dec.sv
module bar_wr_dec #(
   parameter int NUM_SLOTS = 6,
   localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     idx,
   input  logic                 we,
   output logic [NUM_SLOTS-1:0] sel
);

   always_comb begin
      sel = '0;
      for (int j = 0; j < NUM_SLOTS; j++)
         if (we && (32'(idx) == j)) sel[j] = 1'b1;
   end

   p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

   p_oob_nosel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(idx) >= NUM_SLOTS) |-> (sel == '0));

endmodule

// File: rtl/bar_slot.sv
module bar_slot #(
   parameter logic [31:0] WMASK = 32'hFFFF_F000,
   parameter logic [31:0] ROVAL = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic [31:0] val
);
   import bar_bank_pkg::*;

   initial begin
      if ((WMASK & ROVAL) != 32'h0)
         $error("bar_slot: writable and constant bits overlap");
   end

   logic [31:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= be_merge(q, wdata, be) & WMASK;
   end

   assign val   = q;
   assign rdata = q | ROVAL;

   p_masked_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~WMASK) == 32'h0);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));

   p_byte_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !be[0]) |=> (q[7:0] == $past(q[7:0])));

   p_full_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && be == 4'hF) |=> (q == ($past(wdata) & WMASK)));

endmodule

// File: rtl/bar_rd_mux.sv
module bar_rd_mux #(
   parameter int NUM_SLOTS = 6,
   localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      slot_rd [NUM_SLOTS],
   output logic [31:0]      rdata
);

   always_comb begin
      rdata = '0;
      for (int j = 0; j < NUM_SLOTS; j++)
         if (32'(idx) == j) rdata = slot_rd[j];
   end

endmodule

// File: rtl/bar_bank.sv
module bar_bank #(
   parameter int NUM_SLOTS = 6,
   parameter int LOG2_W    = 6,
   parameter logic [NUM_SLOTS*LOG2_W-1:0] SLOT_LOG2 =
      {6'd20, 6'd0, 6'd8, 6'd0, 6'd16, 6'd12},
   parameter logic [NUM_SLOTS-1:0] SLOT_IO   = 6'b001000,
   parameter logic [NUM_SLOTS-1:0] SLOT_IS64 = 6'b000010,
   parameter logic [NUM_SLOTS-1:0] SLOT_PREF = 6'b000010,
   localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [IDX_W-1:0]        cfg_idx,
   input  logic                    cfg_we,
   input  logic [3:0]              cfg_be,
   input  logic [31:0]             cfg_wdata,
   output logic [31:0]             cfg_rdata,
   output logic [NUM_SLOTS*64-1:0] base_addr_o
);
   import bar_bank_pkg::*;

   if (NUM_SLOTS < 1 || NUM_SLOTS > 6) begin : g_bad_count
      initial $error("bar_bank: NUM_SLOTS must be 1..6");
   end
   if (LOG2_W < 6) begin : g_bad_lw
      initial $error("bar_bank: LOG2_W must hold 0..63");
   end

   logic [NUM_SLOTS-1:0] sel;
   logic [31:0]          slot_rd  [NUM_SLOTS];
   logic [31:0]          slot_val [NUM_SLOTS];

   bar_wr_dec #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
      .clk  (clk),
      .rst_n(rst_n),
      .idx  (cfg_idx),
      .we   (cfg_we),
      .sel  (sel)
   );

   for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_slot
      localparam int unsigned LG     = 32'(SLOT_LOG2[j*LOG2_W +: LOG2_W]);
      localparam int unsigned LG_LO  = 32'(SLOT_LOG2[((j > 0) ? j-1 : 0)*LOG2_W +: LOG2_W]);
      localparam logic        PAIRED = (j > 0) ? SLOT_IS64[(j > 0) ? j-1 : 0] : 1'b0;
      localparam slot_role_e  ROLE   = PAIRED ? SLOT_HI64 :
                                       (LG == 0) ? SLOT_OFF :
                                       SLOT_IS64[j] ? SLOT_LO64 : SLOT_LO32;
      localparam logic [3:0]  ATTR   = attr_bits(SLOT_IO[j], SLOT_IS64[j], SLOT_PREF[j]);
      localparam logic [31:0] WMASK  = (ROLE == SLOT_HI64) ? hi_wmask(LG_LO) :
                                       (ROLE == SLOT_OFF)  ? 32'h0 : lo_wmask(LG);
      localparam logic [31:0] ROVAL  = (ROLE == SLOT_LO32 || ROLE == SLOT_LO64) ?
                                       {28'h0, ATTR} : 32'h0;

      // elaboration-time parameter checks
      if (LG != 0 && LG < 4) begin : g_err_small
         initial $error("bar_bank: slot window below 16 bytes");
      end
      if (SLOT_IS64[j] && j == NUM_SLOTS-1) begin : g_err_last
         initial $error("bar_bank: 64-bit window in last slot");
      end
      if (SLOT_IS64[j] && SLOT_IO[j]) begin : g_err_io64
         initial $error("bar_bank: I/O window cannot be 64-bit");
      end
      if (!SLOT_IS64[j] && LG > 31) begin : g_err_big32
         initial $error("bar_bank: 32-bit window above 2 GiB");
      end
      if (PAIRED && (LG != 0 || SLOT_IS64[j])) begin : g_err_hi
         initial $error("bar_bank: upper slot must have no window of its own");
      end

      bar_slot #(.WMASK(WMASK), .ROVAL(ROVAL)) u_slot (
         .clk  (clk),
         .rst_n(rst_n),
         .wr_en(sel[j]),
         .be   (cfg_be),
         .wdata(cfg_wdata),
         .rdata(slot_rd[j]),
         .val  (slot_val[j])
      );

      logic [63:0] base;
      if (ROLE == SLOT_LO64) begin : g_b64
         assign base = {slot_val[(j+1 < NUM_SLOTS) ? j+1 : j], slot_val[j]};
      end else if (ROLE == SLOT_LO32) begin : g_b32
         assign base = {32'h0, slot_val[j]};
      end else begin : g_bz
         assign base = 64'h0;
      end
      assign base_addr_o[j*64 +: 64] = base;

      localparam logic [63:0] ALIGN = (LG == 0) ? 64'h0 : ((64'd1 << LG) - 64'd1);

      p_base_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (base_addr_o[j*64 +: 64] & ALIGN) == 64'h0);

      p_attr_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
         ((32'(cfg_idx) == j) && (ROLE == SLOT_LO32 || ROLE == SLOT_LO64))
            |-> (cfg_rdata[3:0] == ATTR));
   end

   bar_rd_mux #(.NUM_SLOTS(NUM_SLOTS)) u_rd (
      .idx    (cfg_idx),
      .slot_rd(slot_rd),
      .rdata  (cfg_rdata)
   );

   p_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(cfg_idx) >= NUM_SLOTS) |-> (cfg_rdata == 32'h0));

endmodule

// File: tb/sim_bar_bank.sv
module sim_bar_bank;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   cfg_idx = '0;
   logic         cfg_we = 1'b0;
   logic [3:0]   cfg_be = '0;
   logic [31:0]  cfg_wdata = '0;
   logic [31:0]  cfg_rdata;
   logic [383:0] base_addr_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   bar_bank u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_idx    (cfg_idx),
      .cfg_we     (cfg_we),
      .cfg_be     (cfg_be),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .base_addr_o(base_addr_o)
   );

   typedef struct packed {
      logic [2:0]  idx;
      logic [3:0]  be;
      logic [31:0] wd;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_F000, 4'd3}, // R3 4 KiB sizing
      '{3'd0, 4'hF, 32'h0000_1080, 32'h0000_1000, 4'd1}, // R1 truncation
      '{3'd0, 4'hF, 32'hABCD_0FFF, 32'hABCD_0000, 4'd1}, // R1
      '{3'd1, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_000C, 4'd3}, // R3 64-bit prefetch
      '{3'd2, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd4}, // R4 upper slot
      '{3'd2, 4'hF, 32'h1234_5678, 32'h1234_5678, 4'd4}, // R4
      '{3'd1, 4'hF, 32'h0005_0003, 32'h0005_000C, 4'd2}, // R2 attribute kept
      '{3'd3, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FF01, 4'd3}, // R3 I/O
      '{3'd3, 4'hF, 32'h0000_1234, 32'h0000_1201, 4'd1}, // R1
      '{3'd4, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000, 4'd5}, // R5 unimplemented
      '{3'd5, 4'hF, 32'hFFFF_FFFF, 32'hFFF0_0000, 4'd3}, // R3 1 MiB
      '{3'd5, 4'h4, 32'h00AA_0000, 32'hFFA0_0000, 4'd6}, // R6 byte 2
      '{3'd5, 4'h8, 32'h1200_0000, 32'h12A0_0000, 4'd6}, // R6 byte 3
      '{3'd0, 4'h1, 32'hFFFF_FFFF, 32'hABCD_0000, 4'd6}, // R6 byte 0 only
      '{3'd0, 4'h2, 32'h0000_FF00, 32'hABCD_F000, 4'd6}  // R6 byte 1
   };

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [3:0] be,
                     input logic [31:0] wd);
      @(negedge clk);
      cfg_idx = idx; cfg_be = be; cfg_wdata = wd; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
   endtask

   task automatic rd_check(input string req, input logic [2:0] idx,
                           input logic [31:0] exp);
      cfg_idx = idx;
      #1;
      check(req, {32'h0, cfg_rdata}, {32'h0, exp});
   endtask

   task automatic reset_check();
      rd_check("R7", 3'd0, 32'h0000_0000);
      rd_check("R7", 3'd1, 32'h0000_000C);
      rd_check("R7", 3'd2, 32'h0000_0000);
      rd_check("R7", 3'd3, 32'h0000_0001);
      rd_check("R7", 3'd5, 32'h0000_0000);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reset_check();
      check("R7 base", base_addr_o[63:0], 64'h0);

      for (int i = 0; i < NV; i++) begin
         wr(VEC[i].idx, VEC[i].be, VEC[i].wd);
         rd_check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].idx, VEC[i].exp);
      end

      // R8 base outputs
      check("R8 slot0", base_addr_o[0*64 +: 64], 64'h0000_0000_ABCD_F000);
      check("R8 slot1", base_addr_o[1*64 +: 64], 64'h1234_5678_0005_0000);
      check("R8 slot2", base_addr_o[2*64 +: 64], 64'h0);
      check("R8 slot3", base_addr_o[3*64 +: 64], 64'h0000_0000_0000_1200);
      check("R8 slot4", base_addr_o[4*64 +: 64], 64'h0);
      check("R8 slot5", base_addr_o[5*64 +: 64], 64'h0000_0000_12A0_0000);

      // R9 no strobe: no change
      @(negedge clk);
      cfg_idx = 3'd0; cfg_be = 4'hF; cfg_wdata = 32'h0; cfg_we = 1'b0;
      @(negedge clk);
      rd_check("R9", 3'd0, 32'hABCD_F000);

      // R5 out-of-range index
      wr(3'd6, 4'hF, 32'hFFFF_FFFF);
      rd_check("R5 idx6", 3'd6, 32'h0);
      rd_check("R5 idx7", 3'd7, 32'h0);
      rd_check("R5 slot0 kept", 3'd0, 32'hABCD_F000);
      rd_check("R5 slot5 kept", 3'd5, 32'h12A0_0000);

      // R2 attribute bits survive a write of zero
      wr(3'd1, 4'hF, 32'h0);
      rd_check("R2", 3'd1, 32'h0000_000C);
      wr(3'd3, 4'hF, 32'h0000_000E);
      rd_check("R2 io", 3'd3, 32'h0000_0001);

      // R7 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      reset_check();
      check("R7 base5", base_addr_o[5*64 +: 64], 64'h0);

      finish_run();
   end

endmodule